// File: doc/BRIEF.md
# SD Card SPI-Mode Command Transaction Engine

This block carries out one complete command exchange with a memory card in SPI mode. The host side supplies a 6-bit command index, a 32-bit argument, and a count of trailing response bytes. That count is 0 for a plain status reply and 4 for a status byte followed by a 32-bit word. The engine lowers chip select and sends the six-byte command frame. It picks the frame's check byte by itself. It then keeps clocking filler bytes until the card answers with a byte whose top bit is clear. That byte is the status. Any trailing bytes are collected into a right-aligned payload word.

The serial shifter is not part of the block. It is reached through a byte handshake: the engine presents a byte with a one-cycle request, and the shifter returns the received byte with a one-cycle completion pulse. After a reply or a timeout, the engine raises chip select and exchanges one more filler byte so that the card lets go of its data line. A hold input can keep the card selected after a successful reply, so that a data phase can follow in the same transaction.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, chip select (active low) is high, busy and done are low, and no byte request is issued.
- R2: A command sends six bytes with chip select already low: first `0x40 | index`, then the argument from its most significant byte down to its least significant byte, then the check byte.
- R3: The check byte is 0x87 when the index is 8 and the argument is 0x000001AA; for every other index and argument it is 0x95.
- R4: After the frame the engine sends 0xFF repeatedly. The first received byte with bit 7 equal to 0 becomes the status output, whatever its other bits are. Received bytes with bit 7 set, including values other than 0xFF, are skipped.
- R5: When POLL_LIMIT (default 5000) poll bytes in a row all have bit 7 set, the engine reports timed_out=1, status 0xFF and payload 0. A status byte that arrives on exactly the POLL_LIMIT-th poll byte is accepted as a normal reply.
- R6: After the status byte, n further 0xFF bytes are exchanged, where n is the extra-byte count; a count above 4 is treated as 4. The received bytes are shifted into the payload first byte most significant, so the last byte lands in bits 7:0 and unused upper bytes are 0.
- R7: After a reply with hold low, or after any timeout, chip select goes high and exactly one 0xFF byte is exchanged with chip select high before done.
- R8: After a reply with hold high, no release byte is sent and chip select stays low after done. A timeout releases the card even when hold is high.
- R9: Each byte request lasts one cycle, and no new request is issued until the completion pulse for the previous byte has arrived.
- R10: done is a one-cycle pulse. Status, payload and timeout flag hold their values from done until the next accepted start, and a start pulse during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transaction (accepted when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| extra_bytes | input | 3 | Trailing response bytes to collect (0..4, larger clamps to 4) |
| hold_sel | input | 1 | Keep chip select low after a successful reply |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_tx_start | output | 1 | One-cycle byte exchange request |
| spi_rx_byte | input | 8 | Byte shifted in, valid with spi_rx_done |
| spi_rx_done | input | 1 | One-cycle byte exchange completion |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| r1_status | output | 8 | Status byte (0xFF on timeout) |
| payload | output | 32 | Trailing response bytes, right aligned |
| timed_out | output | 1 | No reply within the poll limit |

## Verification
Several rules are checked on every cycle. Each byte request lasts one cycle, and every frame byte goes out with chip select low. The first frame byte carries the 01 start pattern. The release byte goes out with chip select high. The done pulse lasts one cycle, the results stay frozen while idle, and the poll counter never passes its limit. Only the bench scenarios can show the byte order and content of whole transactions. They cover the check-byte selection and the status hunt past non-filler busy bytes. They also cover payload alignment for each count, the exact poll-limit boundary on both sides, hold versus release, and a start that arrives while a transaction is running.

// File: rtl/sdce_pkg.sv
package sdce_pkg;
  localparam int IDX_W   = 6;
  localparam int ARG_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int FRAME_N = 6;

  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] CHK_GENERIC = 8'h95;
  localparam logic [BYTE_W-1:0] CHK_IFCOND  = 8'h87;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FRAME, ST_POLL, ST_TAIL, ST_RELEASE
  } eng_state_t;

  // Check byte selection: the interface-condition probe carries its own value.
  function automatic logic [BYTE_W-1:0] pick_check(input logic [IDX_W-1:0] idx,
                                                   input logic [ARG_W-1:0] arg);
    return (idx == IDX_W'(8) && arg == 32'h0000_01AA) ? CHK_IFCOND : CHK_GENERIC;
  endfunction

  // Byte at a given frame position.
  function automatic logic [BYTE_W-1:0] frame_byte(input logic [IDX_W-1:0] idx,
                                                   input logic [ARG_W-1:0] arg,
                                                   input logic [2:0] pos);
    case (pos)
      3'd0:    return {2'b01, idx};
      3'd1:    return arg[31:24];
      3'd2:    return arg[23:16];
      3'd3:    return arg[15:8];
      3'd4:    return arg[7:0];
      default: return pick_check(idx, arg);
    endcase
  endfunction
endpackage

// File: rtl/sdce_framer.sv
module sdce_framer
  import sdce_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [ARG_W-1:0]  arg,
  input  logic [2:0]        pos,
  output logic [BYTE_W-1:0] byte_out
);
  always_comb byte_out = frame_byte(idx, arg, pos);
endmodule

// File: rtl/sdce_poll_timer.sv
module sdce_poll_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // high while the current poll byte is the final one allowed
  assign last = (cnt == CW'(LIMIT - 1));

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/sdce_collector.sv
module sdce_collector #(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [7:0]        din,
  output logic [8*NBYTES-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (clr)    data <= '0;
    else if (shift)  data <= {data[8*NBYTES-9:0], din};
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdce_pkg::*;
#(
  parameter int POLL_LIMIT = 5000,
  parameter int MAX_EXTRA  = 4,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        cmd_idx,
  input  logic [ARG_W-1:0]        cmd_arg,
  input  logic [CNT_W-1:0]        extra_bytes,
  input  logic                    hold_sel,
  output logic                    spi_cs_n,
  output logic [BYTE_W-1:0]       spi_tx_byte,
  output logic                    spi_tx_start,
  input  logic [BYTE_W-1:0]       spi_rx_byte,
  input  logic                    spi_rx_done,
  output logic                    busy,
  output logic                    done,
  output logic [BYTE_W-1:0]       r1_status,
  output logic [8*MAX_EXTRA-1:0]  payload,
  output logic                    timed_out
);
  localparam logic [CNT_W-1:0] EXTRA_CAP = CNT_W'(MAX_EXTRA);

  eng_state_t        state;
  logic              pend;
  logic [2:0]        pos;
  logic [CNT_W-1:0]  tail_left;
  logic [IDX_W-1:0]  idx_q;
  logic [ARG_W-1:0]  arg_q;
  logic              hold_q;
  logic              cs_n_q;
  logic              done_q;
  logic [BYTE_W-1:0] r1_q;
  logic              to_q;

  // named internal events
  logic start_acc, issue, got, poll_tick, reply_seen, poll_last, tail_shift;
  logic [BYTE_W-1:0] frame_out;

  assign start_acc  = start && (state == ST_IDLE);
  assign issue      = (state != ST_IDLE) && !pend;
  assign got        = pend && spi_rx_done;
  assign poll_tick  = got && (state == ST_POLL);
  assign reply_seen = poll_tick && !spi_rx_byte[7];
  assign tail_shift = got && (state == ST_TAIL);

  sdce_framer u_framer (
    .idx(idx_q), .arg(arg_q), .pos(pos), .byte_out(frame_out)
  );

  sdce_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .tick(poll_tick), .last(poll_last)
  );

  sdce_collector #(.NBYTES(MAX_EXTRA)) u_collect (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .shift(tail_shift),
    .din(spi_rx_byte), .data(payload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      pos       <= '0;
      tail_left <= '0;
      idx_q     <= '0;
      arg_q     <= '0;
      hold_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      r1_q      <= '0;
      to_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (issue)    pend <= 1'b1;
      else if (got) pend <= 1'b0;

      case (state)
        ST_IDLE: if (start) begin
          idx_q     <= cmd_idx;
          arg_q     <= cmd_arg;
          hold_q    <= hold_sel;
          tail_left <= (extra_bytes > EXTRA_CAP) ? EXTRA_CAP : extra_bytes;
          cs_n_q    <= 1'b0;
          pos       <= '0;
          r1_q      <= '0;
          to_q      <= 1'b0;
          state     <= ST_FRAME;
        end
        ST_FRAME: if (got) begin
          if (pos == 3'(FRAME_N - 1)) state <= ST_POLL;
          else                        pos   <= pos + 1'b1;
        end
        ST_POLL: if (reply_seen) begin
          r1_q <= spi_rx_byte;
          if (tail_left != '0) state <= ST_TAIL;
          else if (hold_q) begin state <= ST_IDLE; done_q <= 1'b1; end
          else begin cs_n_q <= 1'b1; state <= ST_RELEASE; end
        end else if (poll_tick && poll_last) begin
          r1_q   <= FILL_BYTE;
          to_q   <= 1'b1;
          cs_n_q <= 1'b1;
          state  <= ST_RELEASE;
        end
        ST_TAIL: if (got) begin
          tail_left <= tail_left - 1'b1;
          if (tail_left == CNT_W'(1)) begin
            if (hold_q) begin state <= ST_IDLE; done_q <= 1'b1; end
            else begin cs_n_q <= 1'b1; state <= ST_RELEASE; end
          end
        end
        ST_RELEASE: if (got) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_tx_start = issue;
  assign spi_tx_byte  = (state == ST_FRAME) ? frame_out : FILL_BYTE;
  assign spi_cs_n     = cs_n_q;
  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign r1_status    = r1_q;
  assign timed_out    = to_q;

  // R2: frame bytes leave with the card selected; the first carries the 01 prefix
  a_r2_frame_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_start && state == ST_FRAME) |-> (!spi_cs_n && (pos != 0 || spi_tx_byte[7:6] == 2'b01)));
  // R7: the release byte is exchanged with chip select high
  a_r7_release_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_start && state == ST_RELEASE) |-> (spi_cs_n && spi_tx_byte == FILL_BYTE));
  // R8: a held successful reply leaves the card selected
  a_r8_hold_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hold_q && !timed_out) |-> !spi_cs_n);
  // R9: one-cycle requests
  a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_start |=> !spi_tx_start);
  // R10: one-cycle completion, results frozen while idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || ($stable(r1_status) && $stable(payload) && $stable(timed_out))));
  // R5: a timeout always reports the filler status
  a_r5_timeout_status: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> (r1_status == FILL_BYTE));
endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, hold_sel = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [2:0] extra_bytes = '0;
  logic spi_cs_n, spi_tx_start, busy, done, timed_out;
  logic [7:0] spi_tx_byte, r1_status;
  logic [7:0] spi_rx_byte = 8'h00;
  logic spi_rx_done = 1'b0;
  logic [31:0] payload;

  int n_tests = 0, n_fail = 0;
  logic [7:0] rxq[$];
  logic [8:0] exp_tx[$];     // {cs_n, byte}
  logic [40:0] exp_res[$];   // {timed_out, r1, payload}

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .extra_bytes(extra_bytes), .hold_sel(hold_sel), .spi_cs_n(spi_cs_n),
    .spi_tx_byte(spi_tx_byte), .spi_tx_start(spi_tx_start), .spi_rx_byte(spi_rx_byte),
    .spi_rx_done(spi_rx_done), .busy(busy), .done(done), .r1_status(r1_status),
    .payload(payload), .timed_out(timed_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // card/shifter model: checks each outgoing byte, answers after two cycles
  initial begin
    forever begin
      @(negedge clk);
      while (spi_tx_start) begin
        if (exp_tx.size() == 0) chk(0, "R2/R9 unexpected byte", {spi_cs_n, spi_tx_byte}, 0);
        else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          if ({spi_cs_n, spi_tx_byte} != e)
            chk(0, "R2/R3/R4/R7 byte stream", {spi_cs_n, spi_tx_byte}, e);
        end
        @(negedge clk);
        chk(!spi_tx_start, "R9 request one cycle", spi_tx_start, 0);
        @(negedge clk);
        spi_rx_byte = (rxq.size() != 0) ? rxq.pop_front() : 8'hFF;
        spi_rx_done = 1'b1;
        @(negedge clk);
        spi_rx_done = 1'b0;
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_res.size() == 0) chk(0, "R10 unexpected done", 0, 1);
        else begin
          logic [40:0] e;
          e = exp_res.pop_front();
          chk({timed_out, r1_status, payload} == e, "R4/R5/R6 result",
              {timed_out, r1_status, payload}, e);
        end
      end
    end
  end

  // driver: builds card replies, expected bytes and expected result
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input int ext,
                         input bit hold, input int waits, input logic [7:0] wait_val,
                         input bit reply, input logic [7:0] r1v, input logic [31:0] pw,
                         input bit poke_start);
    int n;
    logic [7:0] chkb;
    logic [31:0] pexp;
    logic [40:0] res;
    n = (ext > 4) ? 4 : ext;
    chkb = (idx == 6'd8 && arg == 32'h1AA) ? 8'h87 : 8'h95;  // R3
    for (int i = 0; i < 6; i++) rxq.push_back(8'hFF);
    exp_tx.push_back({1'b0, 8'h40 | {2'b00, idx}});           // R2
    for (int i = 3; i >= 0; i--) exp_tx.push_back({1'b0, arg[8*i +: 8]});
    exp_tx.push_back({1'b0, chkb});
    pexp = '0;
    if (reply) begin
      for (int i = 0; i < waits; i++) rxq.push_back(wait_val);
      rxq.push_back(r1v);
      for (int i = 0; i < waits + 1; i++) exp_tx.push_back({1'b0, 8'hFF}); // R4
      for (int k = n - 1; k >= 0; k--) begin
        rxq.push_back(pw[8*k +: 8]);
        exp_tx.push_back({1'b0, 8'hFF});
        pexp = (pexp << 8) | 32'(pw[8*k +: 8]);                // R6
      end
      if (!hold) exp_tx.push_back({1'b1, 8'hFF});               // R7
      res = {1'b0, r1v, pexp};
    end else begin
      for (int i = 0; i < LIMIT; i++) exp_tx.push_back({1'b0, 8'hFF});
      exp_tx.push_back({1'b1, 8'hFF});                          // R5, R8 release
      res = {1'b1, 8'hFF, 32'h0};
    end
    exp_res.push_back(res);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; extra_bytes = 3'(ext); hold_sel = hold; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin   // R10: ignored while busy
      repeat (5) @(negedge clk);
      cmd_idx = 6'h11; cmd_arg = 32'h12345678; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(exp_tx.size() == 0, "R2/R7 all bytes sent", exp_tx.size(), 0);
    chk(spi_cs_n == !(hold && reply), "R7/R8 chip select after done", spi_cs_n, !(hold && reply));
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk({timed_out, r1_status, payload} == res, "R10 results held", {timed_out, r1_status, payload}, res);
    chk(exp_res.size() == 0, "R10 single done", exp_res.size(), 0);
    rxq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !busy && !done && !spi_tx_start, "R1 reset state",
        {spi_cs_n, busy, done, spi_tx_start}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n && !spi_tx_start, "R1 idle after reset", {spi_cs_n, spi_tx_start}, 2'b10);
    // R2/R3 generic check byte, no payload
    run_cmd(6'd0, 32'h0, 0, 0, 1, 8'hFF, 1, 8'h01, 32'h0, 0);
    // R3 interface-condition check byte, R6 full payload
    run_cmd(6'd8, 32'h1AA, 4, 0, 2, 8'hFF, 1, 8'h01, 32'h000001AA, 0);
    // R3 same index, other argument -> generic byte
    run_cmd(6'd8, 32'h2AA, 4, 0, 0, 8'hFF, 1, 8'h05, 32'hDEADBEEF, 0);
    // R6 count above 4 clamps
    run_cmd(6'd58, 32'h0, 7, 0, 3, 8'hFF, 1, 8'h00, 32'hC0FF8000, 0);
    // R6 partial payload right aligned
    run_cmd(6'd13, 32'hA5A5_0F0F, 2, 0, 1, 8'hFF, 1, 8'h40, 32'h0000ABCD, 0);
    // R4 non-filler busy bytes with bit 7 set are skipped; odd status bits kept
    run_cmd(6'd17, 32'h0000_0200, 0, 0, 4, 8'hC3, 1, 8'h7E, 32'h0, 0);
    // R8 hold keeps the card selected
    run_cmd(6'd24, 32'h0000_0400, 0, 1, 1, 8'hFF, 1, 8'h00, 32'h0, 0);
    // R10 start during a transaction ignored (also releases after the held one)
    run_cmd(6'd16, 32'h0000_0200, 1, 0, 2, 8'hFF, 1, 8'h00, 32'h000000AB, 1);
    // R5 reply on the last allowed poll byte
    run_cmd(6'd55, 32'h0, 0, 0, LIMIT - 1, 8'hFF, 1, 8'h01, 32'h0, 0);
    // R5 timeout, released even with hold (R8)
    run_cmd(6'd41, 32'h0, 4, 1, 0, 8'hFF, 0, 8'h00, 32'h0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule